// File: doc/BRIEF.md
# Multicycle RISC instruction controller

This block is a small processor core that runs one instruction at a time. A state machine steps each instruction through fetch, operand read and a class-specific path of execute, memory access and register write-back. The datapath holds a program counter, an instruction register, two operand latches, a result register and a write-back register around a 32 x 32-bit register file. Instruction fetch and data access share one synchronous memory port whose read data arrives one cycle after the address.

The core handles register-register and register-immediate ALU operations, word loads and stores, two conditional branches and an absolute jump. Each retired instruction raises a one-cycle done pulse. Alongside it the core reports the instruction address, whether a register was written, which register, and the value. A bench or a reference model can follow the architectural state from that report alone.

Top module: `mc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and enters the fetch state. While reset is held and in the cycle after it, done and mem_we are low and mem_addr is 0.
- R2: The register-register form is opcode 0x00 with rs in bits 25:21, rt in 20:16, rd in 15:11 and a function code in bits 10:0. Codes 0 to 7 select, in order, add, subtract, and, or, xor, signed set-less-than, and shift left and shift right logical of rs by rt[4:0]. The result is written to rd.
- R3: The immediate forms ADDI 0x08, SLTI 0x0A, ANDI 0x0C, ORI 0x0D and XORI 0x0E apply their operation to rs and the sign-extended bits 15:0. The result is written to rt.
- R4: A load, opcode 0x23, reads the word at rs plus the sign-extended immediate and writes it to rt.
- R5: A store, opcode 0x2B, drives mem_we high for exactly one cycle. It writes rt to the address rs plus the sign-extended immediate and changes no register.
- R6: BEQ 0x04 branches when rs equals rt and BNE 0x05 branches when they differ. The target is the address of the next instruction plus the sign-extended immediate times 4, and neither branch writes a register.
- R7: The jump, opcode 0x02, sets the program counter to the top 4 bits of the next instruction's address, then bits 25:0 of the instruction, then two zero bits.
- R8: Register 0 reads as zero. A result aimed at it is dropped and is reported with commit_we low.
- R9: Measured from one done pulse to the next, the instruction classes take fixed cycle counts: ALU operations 6, loads 7, stores 5, and branches, jumps and unknown instructions 4.
- R10: Done is a one-cycle pulse per retired instruction, and commit_we is high only with it. When no register is written, commit_rd and commit_data read 0. An unknown opcode, or a register-register function code above 7, retires with no register write and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address for the shared memory port |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store write enable |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| done | output | 1 | Pulse when an instruction retires |
| commit_pc | output | 32 | Address of the retired instruction |
| commit_we | output | 1 | The retired instruction wrote a register |
| commit_rd | output | 5 | Register written, 0 if none |
| commit_data | output | 32 | Value written, 0 if none |

## Verification
A single program is run through the core and its retirement stream is compared with a precomputed table, entry by entry. The table holds the address, the write, the value and the cycle count since the previous retirement. The operands mix a small positive number with a negative one, so signed and unsigned comparison differ, shifts fill with different bits, and sign extension of immediates changes results. Memory is reached with positive and negative offsets. Branches are tried taken, not taken and backward, and a jump skips code, so a wrong target shows up as a wrong commit address. Writes to register 0, an unknown opcode, and a reset in the middle of the run check the dropped-write, no-effect and restart cases.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OPC_RR   = 6'h00;
  localparam logic [5:0] OPC_J    = 6'h02;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_BNE  = 6'h05;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_SLTI = 6'h0A;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_XORI = 6'h0E;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4,
    ALU_SLT = 3'd5,
    ALU_SLL = 3'd6,
    ALU_SRL = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    CL_RR,
    CL_RI,
    CL_LD,
    CL_ST,
    CL_BR,
    CL_JMP,
    CL_NOP
  } iclass_e;

  typedef enum logic [2:0] {
    S_FETCH,
    S_IFILL,
    S_DECODE,
    S_EXEC,
    S_ALUWB,
    S_MEM,
    S_LDWAIT,
    S_WRITE
  } state_e;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];

  // Entry 0 is never written; its read is forced to zero.
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) store[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : store[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : store[raddr_b];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] shamt;
  assign shamt = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL: y = a << shamt;
      ALU_SRL: y = a >> shamt;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [10:0] funct,
  output iclass_e     iclass,
  output alu_op_e     alu_op,
  output logic        br_on_ne
);
  always_comb begin
    iclass   = CL_NOP;
    alu_op   = ALU_ADD;
    br_on_ne = 1'b0;
    unique case (opcode)
      OPC_RR: begin
        if (funct[10:3] == '0) begin
          iclass = CL_RR;
          alu_op = alu_op_e'(funct[2:0]);
        end
      end
      OPC_ADDI: begin iclass = CL_RI; alu_op = ALU_ADD; end
      OPC_SLTI: begin iclass = CL_RI; alu_op = ALU_SLT; end
      OPC_ANDI: begin iclass = CL_RI; alu_op = ALU_AND; end
      OPC_ORI:  begin iclass = CL_RI; alu_op = ALU_OR;  end
      OPC_XORI: begin iclass = CL_RI; alu_op = ALU_XOR; end
      OPC_LW:   iclass = CL_LD;
      OPC_SW:   iclass = CL_ST;
      OPC_BEQ:  iclass = CL_BR;
      OPC_BNE:  begin iclass = CL_BR; br_on_ne = 1'b1; end
      OPC_J:    iclass = CL_JMP;
      default:  iclass = CL_NOP;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int          XLEN   = 32,
  parameter logic [31:0] RST_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done,
  output logic [XLEN-1:0] commit_pc,
  output logic            commit_we,
  output logic [4:0]      commit_rd,
  output logic [XLEN-1:0] commit_data
);
  localparam int REG_AW  = 5;
  localparam int IMM_W   = 16;
  localparam int INSTR_B = XLEN / 8;

  state_e          state;
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, r_q, wb_q;

  logic [5:0]        f_op;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd, dest;
  logic [XLEN-1:0]   imm_sx, alu_b, alu_y, rf_a, rf_b, br_target, jmp_target;
  iclass_e           iclass;
  alu_op_e           alu_op;
  logic              br_on_ne, br_taken;

  assign f_op = ir_q[31:26];
  assign f_rs = ir_q[25:21];
  assign f_rt = ir_q[20:16];
  assign f_rd = ir_q[15:11];
  assign imm_sx     = {{(XLEN-IMM_W){ir_q[15]}}, ir_q[15:0]};
  assign br_target  = pc_q + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_q[XLEN-1:28], ir_q[25:0], 2'b00};
  assign dest       = (iclass == CL_RR) ? f_rd : f_rt;
  assign br_taken   = br_on_ne ? (a_q != b_q) : (a_q == b_q);
  assign alu_b      = (iclass == CL_RR) ? b_q : imm_sx;

  mc_decode i_decode (
    .opcode   (f_op),
    .funct    (ir_q[10:0]),
    .iclass   (iclass),
    .alu_op   (alu_op),
    .br_on_ne (br_on_ne)
  );

  mc_alu #(.W(XLEN)) i_alu (
    .op (alu_op),
    .a  (a_q),
    .b  (alu_b),
    .y  (alu_y)
  );

  mc_regfile #(.W(XLEN), .AW(REG_AW)) i_rf (
    .clk     (clk),
    .we      (state == S_WRITE),
    .waddr   (dest),
    .wdata   (wb_q),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  // Shared memory port: instruction address except in the data access state.
  assign mem_addr  = (state == S_MEM) ? r_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = (state == S_MEM) && (iclass == CL_ST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_FETCH;
      pc_q        <= RST_PC;
      ir_q        <= '0;
      a_q         <= '0;
      b_q         <= '0;
      r_q         <= '0;
      wb_q        <= '0;
      done        <= 1'b0;
      commit_pc   <= '0;
      commit_we   <= 1'b0;
      commit_rd   <= '0;
      commit_data <= '0;
    end else begin
      done        <= 1'b0;
      commit_we   <= 1'b0;
      commit_rd   <= '0;
      commit_data <= '0;
      unique case (state)
        S_FETCH: state <= S_IFILL;
        S_IFILL: begin
          ir_q  <= mem_rdata;
          pc_q  <= pc_q + INSTR_B;
          state <= S_DECODE;
        end
        S_DECODE: begin
          a_q   <= rf_a;
          b_q   <= rf_b;
          state <= S_EXEC;
        end
        S_EXEC: begin
          unique case (iclass)
            CL_RR, CL_RI: begin
              r_q   <= alu_y;
              state <= S_ALUWB;
            end
            CL_LD, CL_ST: begin
              r_q   <= a_q + imm_sx;
              state <= S_MEM;
            end
            CL_BR: begin
              if (br_taken) pc_q <= br_target;
              done      <= 1'b1;
              commit_pc <= pc_q - INSTR_B;
              state     <= S_FETCH;
            end
            CL_JMP: begin
              pc_q      <= jmp_target;
              done      <= 1'b1;
              commit_pc <= pc_q - INSTR_B;
              state     <= S_FETCH;
            end
            default: begin
              done      <= 1'b1;
              commit_pc <= pc_q - INSTR_B;
              state     <= S_FETCH;
            end
          endcase
        end
        S_ALUWB: begin
          wb_q  <= r_q;
          state <= S_WRITE;
        end
        S_MEM: begin
          if (iclass == CL_ST) begin
            done      <= 1'b1;
            commit_pc <= pc_q - INSTR_B;
            state     <= S_FETCH;
          end else begin
            state <= S_LDWAIT;
          end
        end
        S_LDWAIT: begin
          wb_q  <= mem_rdata;
          state <= S_WRITE;
        end
        S_WRITE: begin
          done      <= 1'b1;
          commit_pc <= pc_q - INSTR_B;
          if (dest != '0) begin
            commit_we   <= 1'b1;
            commit_rd   <= dest;
            commit_data <= wb_q;
          end
          state <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  // R8: operand latches taken from register 0 hold zero
  a_r8_zero_rs: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && f_rs == '0) |-> (a_q == '0));
  a_r8_zero_rt: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && f_rt == '0) |-> (b_q == '0));
  // R5: a store write lasts one cycle
  a_r5_we_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  // R10: done is a single-cycle pulse and a register report only comes with it
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_commit_with_done: assert property (@(posedge clk) disable iff (rst)
    commit_we |-> done);
  // R6: branch and jump targets keep word alignment
  a_r6_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);
  // R7: after a jump the target field sits in the program counter
  a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && iclass == CL_JMP) |=> (pc_q[27:2] == $past(ir_q[25:0])));
endmodule

// File: tb/test_mc_core.sv
module test_mc_core;
  localparam int CLK_PERIOD = 10;
  localparam int N_EXP      = 29;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, done, commit_we;
  logic [31:0] commit_pc, commit_data;
  logic [4:0]  commit_rd;

  int checks = 0;
  int fails  = 0;
  int store_cnt = 0;
  int cycles_total = 0;
  bit timed_out = 1'b0;

  logic [31:0] mem [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:2]];
    if (!rst && mem_we) store_cnt <= store_cnt + 1;
  end

  mc_core i_mc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .done(done),
    .commit_pc(commit_pc), .commit_we(commit_we), .commit_rd(commit_rd),
    .commit_data(commit_data)
  );

  // {cycles since previous retire (0 = not checked), pc, we, rd, data}
  localparam logic [73:0] EXP [N_EXP] = '{
    {4'd0, 32'h00, 1'b1, 5'd1,  32'h00000005},
    {4'd6, 32'h04, 1'b1, 5'd2,  32'hFFFFFFFD},
    {4'd6, 32'h08, 1'b1, 5'd3,  32'h00000002},
    {4'd6, 32'h0C, 1'b1, 5'd4,  32'h00000008},
    {4'd6, 32'h10, 1'b1, 5'd5,  32'h00000005},
    {4'd6, 32'h14, 1'b1, 5'd6,  32'hFFFFFFFD},
    {4'd6, 32'h18, 1'b1, 5'd7,  32'hFFFFFFF8},
    {4'd6, 32'h1C, 1'b1, 5'd8,  32'h00000001},
    {4'd6, 32'h20, 1'b0, 5'd0,  32'h00000000},
    {4'd6, 32'h24, 1'b1, 5'd9,  32'h00000005},
    {4'd5, 32'h28, 1'b0, 5'd0,  32'h00000000},
    {4'd7, 32'h2C, 1'b1, 5'd10, 32'h00000008},
    {4'd6, 32'h30, 1'b1, 5'd12, 32'h00000200},
    {4'd7, 32'h34, 1'b1, 5'd11, 32'hCAFEF00D},
    {4'd7, 32'h38, 1'b1, 5'd13, 32'h12345678},
    {4'd4, 32'h3C, 1'b0, 5'd0,  32'h00000000},
    {4'd4, 32'h44, 1'b0, 5'd0,  32'h00000000},
    {4'd6, 32'h48, 1'b1, 5'd15, 32'h00007FFF},
    {4'd4, 32'h4C, 1'b0, 5'd0,  32'h00000000},
    {4'd6, 32'h58, 1'b1, 5'd16, 32'h000FFFE0},
    {4'd6, 32'h5C, 1'b1, 5'd17, 32'h07FFFFFF},
    {4'd6, 32'h60, 1'b1, 5'd18, 32'h00000001},
    {4'd6, 32'h64, 1'b1, 5'd19, 32'hFFFFFFFA},
    {4'd6, 32'h68, 1'b1, 5'd20, 32'hFFFF8000},
    {4'd6, 32'h6C, 1'b1, 5'd21, 32'h000000F0},
    {4'd4, 32'h70, 1'b0, 5'd0,  32'h00000000},
    {4'd5, 32'h74, 1'b0, 5'd0,  32'h00000000},
    {4'd4, 32'h78, 1'b0, 5'd0,  32'h00000000},
    {4'd4, 32'h78, 1'b0, 5'd0,  32'h00000000}
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1, 12, 17, 21, 22, 23, 24: return "R3";
      2, 3, 4, 5, 6, 7, 19, 20:     return "R2";
      8, 9:                         return "R8";
      10, 26:                       return "R5";
      11, 13, 14:                   return "R4";
      15, 16, 27, 28:               return "R6";
      18:                           return "R7";
      default:                      return "R10";
    endcase
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [10:0] fn);
    return {6'h00, rs, rt, rd, fn};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      cycles_total++;
      if (cycles_total > WATCHDOG) begin
        timed_out = 1'b1;
        return;
      end
    end while (!done);
  endtask

  initial begin
    int n;
    for (int k = 0; k < 1024; k++) mem[k] = 32'h0;
    mem[0]  = enc_i(6'h08, 5'd0, 5'd1, 16'd5);
    mem[1]  = enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD);
    mem[2]  = enc_r(5'd1, 5'd2, 5'd3, 11'd0);
    mem[3]  = enc_r(5'd1, 5'd2, 5'd4, 11'd1);
    mem[4]  = enc_r(5'd1, 5'd2, 5'd5, 11'd2);
    mem[5]  = enc_r(5'd1, 5'd2, 5'd6, 11'd3);
    mem[6]  = enc_r(5'd1, 5'd2, 5'd7, 11'd4);
    mem[7]  = enc_r(5'd2, 5'd1, 5'd8, 11'd5);
    mem[8]  = enc_i(6'h08, 5'd0, 5'd0, 16'd7);
    mem[9]  = enc_r(5'd0, 5'd1, 5'd9, 11'd0);
    mem[10] = enc_i(6'h2B, 5'd0, 5'd4, 16'h0200);
    mem[11] = enc_i(6'h23, 5'd0, 5'd10, 16'h0200);
    mem[12] = enc_i(6'h08, 5'd0, 5'd12, 16'h0200);
    mem[13] = enc_i(6'h23, 5'd12, 5'd11, 16'd4);
    mem[14] = enc_i(6'h23, 5'd12, 5'd13, 16'hFFFC);
    mem[15] = enc_i(6'h04, 5'd1, 5'd9, 16'd1);
    mem[16] = enc_i(6'h08, 5'd0, 5'd14, 16'd1);
    mem[17] = enc_i(6'h05, 5'd1, 5'd9, 16'd5);
    mem[18] = enc_i(6'h08, 5'd0, 5'd15, 16'h7FFF);
    mem[19] = {6'h02, 26'd22};
    mem[20] = enc_i(6'h08, 5'd0, 5'd14, 16'd2);
    mem[21] = enc_i(6'h08, 5'd0, 5'd14, 16'd2);
    mem[22] = enc_r(5'd15, 5'd1, 5'd16, 11'd6);
    mem[23] = enc_r(5'd6, 5'd1, 5'd17, 11'd7);
    mem[24] = enc_i(6'h0A, 5'd2, 5'd18, 16'hFFFE);
    mem[25] = enc_i(6'h0E, 5'd1, 5'd19, 16'hFFFF);
    mem[26] = enc_i(6'h0D, 5'd0, 5'd20, 16'h8000);
    mem[27] = enc_i(6'h0C, 5'd6, 5'd21, 16'h00F0);
    mem[28] = 32'hFC00_0000;
    mem[29] = enc_i(6'h2B, 5'd12, 5'd20, 16'd8);
    mem[30] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
    mem[127] = 32'h12345678;
    mem[129] = 32'hCAFEF00D;

    // R1: reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done in reset", {31'd0, done}, 32'd0);
    check("R1 mem_we in reset", {31'd0, mem_we}, 32'd0);
    check("R1 mem_addr in reset", mem_addr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 fetch address after reset", mem_addr, 32'd0);
    check("R1 done after reset", {31'd0, done}, 32'd0);

    for (int i = 0; i < N_EXP && !timed_out; i++) begin
      wait_done(n);
      if (timed_out) break;
      if (EXP[i][73:70] != 4'd0)
        check($sformatf("R9 cycles entry %0d", i), n, {28'd0, EXP[i][73:70]});
      check($sformatf("%s pc entry %0d", req_of(i), i), commit_pc, EXP[i][69:38]);
      check($sformatf("%s we entry %0d", req_of(i), i), {31'd0, commit_we}, {31'd0, EXP[i][37]});
      check($sformatf("%s rd entry %0d", req_of(i), i), {27'd0, commit_rd}, {27'd0, EXP[i][36:32]});
      check($sformatf("%s data entry %0d", req_of(i), i), commit_data, EXP[i][31:0]);
    end

    if (!timed_out) begin
      // R5: stored words; R10: the unknown opcode added no store
      check("R5 stored word at 0x200", mem[128], 32'h00000008);
      check("R5 stored word at 0x208", mem[130], 32'hFFFF8000);
      check("R10 store count", store_cnt, 32'd2);
      check("R4 preloaded word untouched", mem[129], 32'hCAFEF00D);

      // R1: reset in the middle of the run restarts at address 0
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 mid-run reset mem_addr", mem_addr, 32'd0);
      check("R1 mid-run reset done", {31'd0, done}, 32'd0);
      rst = 1'b0;
      wait_done(n);
      if (!timed_out) begin
        check("R1 restart pc", commit_pc, 32'd0);
        check("R1 restart data", commit_data, 32'd5);
        @(negedge clk);
        check("R10 done falls", {31'd0, done}, 32'd0);
      end
    end

    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles_total, WATCHDOG);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule